// File: doc/BRIEF.md
# Radix-8 Booth Recoded Multiplier

This block multiplies two 8-bit operands and returns their full 16-bit product one clock later. A single mode input selects whether both operands are taken as two's complement numbers or as plain unsigned magnitudes, and it can change on every operation. Inside, the multiplier operand is rewritten as a short string of signed radix-8 digits in the range -4..+4. Only three partial products are produced instead of eight.

Each digit picks one multiple of the multiplicand: zero, one, two, three or four times it, with an optional negation. The "three times" multiple has no simple shift form. A dedicated adder builds it from the multiplicand plus the multiplicand shifted left by one, before any digit selects it. A negative digit inverts its chosen multiple. The missing +1 goes into a separate correction row at that digit's lowest weight. All rows are sign-extended to the product width, so the sum is exact modulo 2^16. A carry-save tree of 3:2 counters reduces the rows to a sum vector and a carry vector. A two-level carry-lookahead adder then merges these two vectors into the product, which is registered.

Top module: `r8booth_mul`

## Requirements
- R1: While `rst` is high at a rising clock edge, `product` becomes 0 at that edge.
- R2: With `op_signed`=0, `product` equals the unsigned product of `mcand` and `mplier`, one clock edge after those inputs are sampled.
- R3: With `op_signed`=1, `product` equals the two's complement product of `mcand` and `mplier` as a 16-bit two's complement value, one clock edge after sampling.
- R4: The multiplier is extended by one bit. The extension is its sign bit in signed mode and 0 in unsigned mode. It is then split into 3 digits. Digit i decodes the window {b[3i+2], b[3i+1], b[3i], b[3i-1]}, with b[-1]=0. Its value is -4*b[3i+2] + 2*b[3i+1] + b[3i] + b[3i-1]. At most one magnitude select (1, 2, 3 or 4) is active per digit, and a negative flag is only raised together with a nonzero magnitude.
- R5: The triple multiple equals 3 times the sign- or zero-extended multiplicand. Operands whose digits are ±3 multiply correctly.
- R6: Negative digits, including -4 and the digit -0 from an all-ones window, give correct products.
- R7: Extreme operands give exact results: signed -128*-128 = 16384, signed -128*127 = -16256, and unsigned 255*255 = 65025.
- R8: The sum and carry vectors leaving the carry-save tree add, modulo 2^16, to the sum of all partial-product and correction rows.
- R9: The mode applies per operation. Back-to-back operations with alternating `op_signed` each give the result for their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_signed | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| mcand | input | 8 | Multiplicand |
| mplier | input | 8 | Multiplier, recoded into radix-8 digits |
| product | output | 16 | Registered product |

## Verification
The bench sweeps every operand pair in both modes. This catches a wrong window boundary, which would drop or double-count one bit weight, and a wrong extension bit, which would flip the sign of the top digit for multipliers of 128 and above. Directed groups go after the -4 and all-ones windows. These are where a bad negation or a missing correction-row bit would leave products off by one multiple or by 2^(3i). Further groups target ±3 digits, which expose a faulty triple adder, the extreme corners, where sign extension of the rows must be exact, and mode toggling on every cycle, which would catch any mode that lags by one operation.

// File: rtl/r8booth_pkg.sv
package r8booth_pkg;

  // Digit select: {neg, onehot magnitude (bit0=1, bit1=2, bit2=3, bit3=4)}
  typedef logic [4:0] dsel_t;

  // Window bit order: {b2, b1, b0, b_prev}
  function automatic dsel_t decode_window(input logic [3:0] w);
    dsel_t d;
    case (w)
      4'b0000, 4'b1111: d = 5'b0_0000;
      4'b0001, 4'b0010: d = 5'b0_0001;
      4'b0011, 4'b0100: d = 5'b0_0010;
      4'b0101, 4'b0110: d = 5'b0_0100;
      4'b0111:          d = 5'b0_1000;
      4'b1000:          d = 5'b1_1000;
      4'b1001, 4'b1010: d = 5'b1_0100;
      4'b1011, 4'b1100: d = 5'b1_0010;
      default:          d = 5'b1_0001;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/r8booth_enc.sv
module r8booth_enc
  import r8booth_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic [3*NDIG-1:0]      mplier_x,
  output logic [NDIG-1:0]        dneg,
  output logic [NDIG-1:0][3:0]   dmag
);

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] win;
    dsel_t      sel;
    if (i == 0) begin : g_low
      assign win = {mplier_x[2:0], 1'b0};
    end else begin : g_up
      assign win = mplier_x[3*i+2 : 3*i-1];
    end
    assign sel     = decode_window(win);
    assign dneg[i] = sel[4];
    assign dmag[i] = sel[3:0];
  end

endmodule

// File: rtl/r8booth_sel.sv
module r8booth_sel #(
  parameter int NDIG = 3,
  parameter int PW   = 16
) (
  input  logic [PW-1:0]              m1,
  input  logic [PW-1:0]              m2,
  input  logic [PW-1:0]              m3,
  input  logic [PW-1:0]              m4,
  input  logic [NDIG-1:0]            dneg,
  input  logic [NDIG-1:0][3:0]       dmag,
  output logic [NDIG-1:0][PW-1:0]    pp,
  output logic [PW-1:0]              corr
);

  for (genvar i = 0; i < NDIG; i++) begin : g_row
    logic [PW-1:0] pick;
    assign pick = ({PW{dmag[i][0]}} & m1) | ({PW{dmag[i][1]}} & m2) |
                  ({PW{dmag[i][2]}} & m3) | ({PW{dmag[i][3]}} & m4);
    assign pp[i] = (pick ^ {PW{dneg[i]}}) << (3 * i);
  end

  // +1 at each negative digit's lowest weight completes the two's complement
  always_comb begin
    corr = '0;
    for (int i = 0; i < NDIG; i++) corr[3*i] = dneg[i];
  end

endmodule

// File: rtl/r8booth_csa_tree.sv
module r8booth_csa_tree #(
  parameter int NROWS = 4,
  parameter int PW    = 16
) (
  input  logic [NROWS-1:0][PW-1:0] rows,
  output logic [PW-1:0]            sum_v,
  output logic [PW-1:0]            carry_v
);

  localparam int NA = NROWS + 2;

  logic [NA-1:0][PW-1:0] cur, nxt;

  // Wallace-style: each level splits the rows into groups of three,
  // compresses every full group with 3:2 counters, passes leftovers on.
  always_comb begin
    int n;
    int m;
    cur = '0;
    nxt = '0;
    for (int r = 0; r < NROWS; r++) cur[r] = rows[r];
    n = NROWS;
    for (int lvl = 0; lvl < NROWS; lvl++) begin
      if (n > 2) begin
        nxt = '0;
        m = 0;
        for (int g = 0; g < NROWS; g += 3) begin
          if (g + 2 < n) begin
            nxt[m]   = cur[g] ^ cur[g+1] ^ cur[g+2];
            nxt[m+1] = ((cur[g] & cur[g+1]) | (cur[g] & cur[g+2]) |
                        (cur[g+1] & cur[g+2])) << 1;
            m = m + 2;
          end else if (g < n) begin
            nxt[m] = cur[g];
            if (g + 1 < n) nxt[m+1] = cur[g+1];
            m = m + (n - g);
          end
        end
        cur = nxt;
        n = m;
      end
    end
    sum_v   = cur[0];
    carry_v = (n > 1) ? cur[1] : '0;
  end

endmodule

// File: rtl/r8booth_cla.sv
module r8booth_cla #(
  parameter int PW  = 16,
  parameter int BLK = 4
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] s
);

  localparam int NB = PW / BLK;

  logic [PW-1:0] g, p, c;
  logic [NB-1:0] bg, bp;
  logic [NB:0]   bc;

  assign g = x & y;
  assign p = x ^ y;

  always_comb begin
    logic t;
    bg = '0;
    bp = '0;
    bc = '0;
    c  = '0;
    // block generate / propagate
    for (int b = 0; b < NB; b++) begin
      bp[b] = &p[b*BLK +: BLK];
      for (int k = 0; k < BLK; k++) begin
        t = g[b*BLK+k];
        for (int l = k + 1; l < BLK; l++) t = t & p[b*BLK+l];
        bg[b] = bg[b] | t;
      end
    end
    // block carries, expanded lookahead (carry-in is zero)
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k <= b; k++) begin
        t = bg[k];
        for (int l = k + 1; l <= b; l++) t = t & bp[l];
        bc[b+1] = bc[b+1] | t;
      end
    end
    // bit carries inside each block
    for (int b = 0; b < NB; b++) begin
      for (int j = 0; j < BLK; j++) begin
        t = bc[b];
        for (int l = 0; l < j; l++) t = t & p[b*BLK+l];
        c[b*BLK+j] = t;
        for (int k = 0; k < j; k++) begin
          t = g[b*BLK+k];
          for (int l = k + 1; l < j; l++) t = t & p[b*BLK+l];
          c[b*BLK+j] = c[b*BLK+j] | t;
        end
      end
    end
  end

  assign s = p ^ c;

endmodule

// File: rtl/r8booth_mul.sv
module r8booth_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_signed,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product
);

  localparam int PW    = 2 * W;
  localparam int NDIG  = (W + 3) / 3;   // ceil((W+1)/3)
  localparam int XB    = 3 * NDIG;
  localparam int NROWS = NDIG + 1;

  logic [PW-1:0] y1, y2, y3, y4;
  logic [XB-1:0] bx;

  assign y1 = op_signed ? {{(PW-W){mcand[W-1]}}, mcand} : {{(PW-W){1'b0}}, mcand};
  assign bx = op_signed ? {{(XB-W){mplier[W-1]}}, mplier} : {{(XB-W){1'b0}}, mplier};
  assign y2 = y1 << 1;
  assign y4 = y1 << 2;

  // hard multiple built ahead of selection
  r8booth_cla #(.PW(PW), .BLK(4)) u_triple (
    .x(y1), .y(y2), .s(y3)
  );

  logic [NDIG-1:0]         dneg;
  logic [NDIG-1:0][3:0]    dmag;
  logic [NDIG-1:0][PW-1:0] pp;
  logic [PW-1:0]           corr;
  logic [NROWS-1:0][PW-1:0] rows_all;
  logic [PW-1:0]           ts, tc, fsum;

  r8booth_enc #(.NDIG(NDIG)) u_enc (
    .mplier_x(bx), .dneg(dneg), .dmag(dmag)
  );

  r8booth_sel #(.NDIG(NDIG), .PW(PW)) u_sel (
    .m1(y1), .m2(y2), .m3(y3), .m4(y4),
    .dneg(dneg), .dmag(dmag), .pp(pp), .corr(corr)
  );

  always_comb begin
    rows_all = '0;
    for (int r = 0; r < NDIG; r++) rows_all[r] = pp[r];
    rows_all[NDIG] = corr;
  end

  r8booth_csa_tree #(.NROWS(NROWS), .PW(PW)) u_tree (
    .rows(rows_all), .sum_v(ts), .carry_v(tc)
  );

  r8booth_cla #(.PW(PW), .BLK(4)) u_final (
    .x(ts), .y(tc), .s(fsum)
  );

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= fsum;
  end

endmodule

// File: rtl/r8booth_chk.sv
module r8booth_chk #(
  parameter int W     = 8,
  parameter int NDIG  = 3,
  parameter int NROWS = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          op_signed,
  input logic [W-1:0]                  mcand,
  input logic [W-1:0]                  mplier,
  input logic [2*W-1:0]                product,
  input logic [NDIG-1:0]               dneg,
  input logic [NDIG-1:0][3:0]          dmag,
  input logic [NROWS-1:0][2*W-1:0]     rows_all,
  input logic [2*W-1:0]                ts,
  input logic [2*W-1:0]                tc,
  input logic [2*W-1:0]                y1,
  input logic [2*W-1:0]                y3
);

  localparam int PW = 2 * W;

  logic [PW-1:0] ref_u, ref_s, rowsum;

  assign ref_u = {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
  assign ref_s = $signed({{W{mcand[W-1]}}, mcand}) * $signed({{W{mplier[W-1]}}, mplier});

  always_comb begin
    rowsum = '0;
    for (int r = 0; r < NROWS; r++) rowsum = rowsum + rows_all[r];
  end

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> product == '0);

  a_r2_unsigned: assert property (@(posedge clk) disable iff (rst)
    !op_signed |=> product == $past(ref_u));

  a_r3_signed: assert property (@(posedge clk) disable iff (rst)
    op_signed |=> product == $past(ref_s));

  for (genvar i = 0; i < NDIG; i++) begin : g_dchk
    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dmag[i]));
    a_r4_neg_nonzero: assert property (@(posedge clk) disable iff (rst)
      dneg[i] |-> (dmag[i] != 4'b0000));
  end

  a_r5_triple: assert property (@(posedge clk) disable iff (rst)
    y3 == PW'(y1 * 3));

  a_r8_tree_sum: assert property (@(posedge clk) disable iff (rst)
    PW'(ts + tc) == rowsum);

endmodule

bind r8booth_mul r8booth_chk #(.W(W), .NDIG(NDIG), .NROWS(NROWS)) u_chk (
  .clk(clk), .rst(rst), .op_signed(op_signed), .mcand(mcand), .mplier(mplier),
  .product(product), .dneg(dneg), .dmag(dmag), .rows_all(rows_all),
  .ts(ts), .tc(tc), .y1(y1), .y3(y3)
);

// File: tb/sim_r8booth_mul.sv
module sim_r8booth_mul;

  localparam int CLK_NS = 10;
  localparam int W      = 8;
  localparam int WD_CYC = 190000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           op_signed = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [2*W-1:0] exp;
    logic [W-1:0]   a;
    logic [W-1:0]   b;
    logic           s;
    string          tag;
  } item_t;

  item_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  r8booth_mul #(.W(W)) u0 (
    .clk(clk), .rst(rst), .op_signed(op_signed),
    .mcand(mcand), .mplier(mplier), .product(product)
  );

  function automatic logic [2*W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic s);
    int p;
    if (s) p = int'($signed(a)) * int'($signed(b));
    else   p = int'(a) * int'(b);
    return p[2*W-1:0];
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic s, string tag);
    item_t it;
    @(negedge clk);
    mcand = a; mplier = b; op_signed = s;
    it.exp = model(a, b, s); it.a = a; it.b = b; it.s = s; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic check_zero(string tag);
    n_checks++;
    if (product !== '0) begin
      n_fails++;
      $display("FAIL %s reset: got %h expected 0000", tag, product);
    end
  endtask

  // monitor: result of an item pushed at a falling edge is registered at the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        n_checks++;
        if (product !== it.exp) begin
          n_fails++;
          $display("FAIL %s a=%h b=%h signed=%0d: got %h expected %h",
                   it.tag, it.a, it.b, it.s, product, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_zero("R1");
    rst = 1'b0;

    // R4: identity multiplicand exposes the recoded multiplier directly
    for (int b = 0; b < 256; b++) drive(8'd1, W'(b), 1'b0, "R4");
    for (int b = 0; b < 256; b++) drive(8'd1, W'(b), 1'b1, "R4");

    // R5: digits of +-3
    drive(8'd77, 8'd3, 1'b0, "R5");
    drive(8'd77, 8'h1B, 1'b0, "R5");
    drive(8'hB3, 8'hFD, 1'b1, "R5");
    drive(8'h7F, 8'hDD, 1'b1, "R5");

    // R6: -4 digits and all-ones windows
    drive(8'h55, 8'h80, 1'b1, "R6");
    drive(8'h55, 8'hFF, 1'b1, "R6");
    drive(8'h55, 8'hFF, 1'b0, "R6");
    drive(8'hC4, 8'h04, 1'b1, "R6");
    drive(8'h39, 8'h24, 1'b0, "R6");

    // R7: extremes
    drive(8'h80, 8'h80, 1'b1, "R7");
    drive(8'h80, 8'h7F, 1'b1, "R7");
    drive(8'hFF, 8'hFF, 1'b0, "R7");
    drive(8'h7F, 8'h7F, 1'b1, "R7");

    // R8: every row populated, long carry chains
    drive(8'hFF, 8'hB6, 1'b1, "R8");
    drive(8'hFF, 8'hB6, 1'b0, "R8");

    // R9: alternating mode on consecutive operations
    for (int k = 0; k < 16; k++) drive(8'hC3, W'(8'h90 + k), k[0], "R9");

    // R2 / R3: exhaustive sweep
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          drive(W'(a), W'(b), s[0], (s == 0) ? "R2" : "R3");

    repeat (3) @(negedge clk);
    // R1: reset clears a nonzero held product
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_zero("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule